// File: doc/BRIEF.md
# Dual-Bank Register Write Port

This block is the host-side write front end of an FM synthesizer. A host presents a 2-bit port number and a data word. A write to an even port stores a register address and a bank bit, which is bit 1 of the port number. A write to an odd port takes the stored bank and address as a 9-bit register address. It then issues one write strobe, tagged by register group, to the register file behind it. The bank comes from the last address write, not from the odd port that carries the data.

After reset is released, the block runs its own initialisation. It writes zero to the mode registers one per clock, from the highest address down to the lowest, and clears the DAC enable, the DAC sample value and the bank bit. A busy flag holds host writes off until the sequence is finished. The block also keeps the DAC enable and DAC sample registers. It emits an LFO counter clear whenever the LFO control register is written with its enable bit low.

Top module: `fm_host_wport`

## Requirements
- R1: A write to port 0 or port 2 stores data bits 7:0 as the register address and stores port bit 1 as the bank bit. It raises no register write strobe.
- R2: A write to port 1 or port 3 raises `reg_we_o` for that one cycle, combinationally. The address is {stored bank, stored address} and the data is data bits 7:0. The bank does not depend on which odd port is used.
- R3: Bits of `data_i` above bit 7 have no effect on any address, data or register.
- R4: A strobe whose address satisfies (addr & 0x1F0) == 0x020 raises `mode_we_o`. Every other strobe raises `chan_we_o`. The two are never high together. Bank-1 addresses 0x120–0x12F are channel writes.
- R5: A write to address 0x022 with data bit 3 (LFO enable) at 0 pulses `lfo_clr_o` in the same cycle. The same write with bit 3 at 1 does not.
- R6: A write to 0x02A loads `dac_data_o` on the next clock edge. A write to 0x02B loads `dac_en_o` from data bit 7 on the next clock edge.
- R7: After reset is released, `busy_o` is high. The first cycle carries no strobe. The next seven cycles carry strobes with data 0 to 0x026, 0x025, ... 0x020, one per clock. `busy_o` falls on the edge after the 0x020 strobe.
- R8: Reset leaves `dac_en_o` at 0, `dac_data_o` at 0, and the bank bit and stored address at 0. A data write issued before any address write therefore targets 0x000.
- R9: Host writes while `busy_o` is high are ignored. Their data never appears on the strobe outputs, and they do not change the stored address or bank.
- R10: The stored address and bank persist. Successive data writes with no address write in between all target the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write request |
| port_i | input | 2 | Port number; bit 0 selects data, bit 1 selects bank on address writes |
| data_i | input | HOST_W | Host data; only bits 7:0 are used |
| busy_o | output | 1 | Initialisation in progress; host writes ignored |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 9 | Register address, bank at bit 8 |
| reg_data_o | output | 8 | Register data |
| mode_we_o | output | 1 | Strobe falls in the mode/global group |
| chan_we_o | output | 1 | Strobe falls outside the mode group |
| lfo_clr_o | output | 1 | LFO counter clear pulse |
| dac_en_o | output | 1 | DAC enable register |
| dac_data_o | output | 8 | DAC sample register |

## Verification
The hardest state to reach is a host write that collides with the initialisation sequence. The bench holds an address write and then a data write on the bus during the busy cycles, and checks that the strobes still show the sequence. The following data write must land on 0x000, which shows that nothing was latched. The bank rule is reached by latching through one even port and writing data through the odd port of the other bank. Random traffic is steered toward 0x20–0x2F so that the LFO and DAC side effects occur often.

// File: rtl/fm_wport_pkg.sv
package fm_wport_pkg;
  localparam int REG_AW = 9;
  localparam int REG_DW = 8;
  localparam logic [4:0] MODE_GRP = 5'h02;
  localparam logic [7:0] LFO_REG = 8'h22;
  localparam int LFO_EN_BIT = 3;
  localparam logic [7:0] DAC_DATA_REG = 8'h2A;
  localparam logic [7:0] DAC_EN_REG = 8'h2B;
  localparam int DAC_EN_BIT = 7;
  localparam logic [7:0] SEQ_FIRST = 8'h26;
  localparam logic [7:0] SEQ_LAST = 8'h20;

  typedef enum logic [1:0] {SEQ_ARM, SEQ_RUN, SEQ_DONE} seq_state_e;

  typedef struct packed {
    logic              we;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/fm_wport_rst_seq.sv
module fm_wport_rst_seq
  import fm_wport_pkg::*;
#(
  parameter logic [7:0] FIRST = SEQ_FIRST,
  parameter logic [7:0] LAST  = SEQ_LAST
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  output logic    busy_o,
  output logic    clr_o,
  output wr_req_t wr_o
);
  seq_state_e state_q;
  logic [7:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_ARM;
      idx_q   <= FIRST;
    end else begin
      unique case (state_q)
        SEQ_ARM: state_q <= SEQ_RUN;
        SEQ_RUN: begin
          if (idx_q == LAST) state_q <= SEQ_DONE;
          else idx_q <= idx_q - 8'd1;
        end
        default: state_q <= SEQ_DONE;
      endcase
    end
  end

  assign busy_o  = (state_q != SEQ_DONE);
  assign clr_o   = (state_q == SEQ_ARM);
  assign wr_o.we = (state_q == SEQ_RUN);
  assign wr_o.addr = {1'b0, idx_q};
  assign wr_o.data = '0;
endmodule

// File: rtl/fm_wport_addr_latch.sv
module fm_wport_addr_latch
  import fm_wport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              bank_i,
  input  logic [7:0]        addr_i,
  output logic [REG_AW-1:0] tgt_o
);
  logic       bank_q;
  logic [7:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
      addr_q <= '0;
    end else if (clr_i) begin
      bank_q <= 1'b0;
    end else if (load_i) begin
      bank_q <= bank_i;
      addr_q <= addr_i;
    end
  end

  assign tgt_o = {bank_q, addr_q};
endmodule

// File: rtl/fm_wport_decode.sv
module fm_wport_decode
  import fm_wport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  wr_req_t           req_i,
  output logic              mode_we_o,
  output logic              chan_we_o,
  output logic              lfo_clr_o,
  output logic              dac_en_o,
  output logic [REG_DW-1:0] dac_data_o
);
  logic in_mode;
  logic hit_dac_data, hit_dac_en;

  // group select: address masked with 0x1F0
  assign in_mode   = (req_i.addr[REG_AW-1:4] == MODE_GRP);
  assign mode_we_o = req_i.we & in_mode;
  assign chan_we_o = req_i.we & ~in_mode;

  assign lfo_clr_o = mode_we_o & (req_i.addr[7:0] == LFO_REG) & ~req_i.data[LFO_EN_BIT];
  assign hit_dac_data = mode_we_o & (req_i.addr[7:0] == DAC_DATA_REG);
  assign hit_dac_en   = mode_we_o & (req_i.addr[7:0] == DAC_EN_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_en_o   <= 1'b0;
      dac_data_o <= '0;
    end else if (clr_i) begin
      dac_en_o   <= 1'b0;
      dac_data_o <= '0;
    end else begin
      if (hit_dac_en)   dac_en_o   <= req_i.data[DAC_EN_BIT];
      if (hit_dac_data) dac_data_o <= req_i.data;
    end
  end
endmodule

// File: rtl/fm_host_wport.sv
module fm_host_wport
  import fm_wport_pkg::*;
#(
  parameter int HOST_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        port_i,
  input  logic [HOST_W-1:0] data_i,
  output logic              busy_o,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [REG_DW-1:0] reg_data_o,
  output logic              mode_we_o,
  output logic              chan_we_o,
  output logic              lfo_clr_o,
  output logic              dac_en_o,
  output logic [REG_DW-1:0] dac_data_o
);
  logic              seq_busy, seq_clr, accept;
  logic [REG_DW-1:0] host_byte;
  logic [REG_AW-1:0] tgt;
  wr_req_t           seq_req, host_req, req;

  assign host_byte = data_i[REG_DW-1:0];
  assign accept    = wr_en_i & ~seq_busy;

  fm_wport_rst_seq u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_o(seq_busy),
    .clr_o (seq_clr),
    .wr_o  (seq_req)
  );

  fm_wport_addr_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (seq_clr),
    .load_i(accept & ~port_i[0]),
    .bank_i(port_i[1]),
    .addr_i(host_byte),
    .tgt_o (tgt)
  );

  assign host_req.we   = accept & port_i[0];
  assign host_req.addr = tgt;
  assign host_req.data = host_byte;
  assign req = seq_busy ? seq_req : host_req;

  fm_wport_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (seq_clr),
    .req_i     (req),
    .mode_we_o (mode_we_o),
    .chan_we_o (chan_we_o),
    .lfo_clr_o (lfo_clr_o),
    .dac_en_o  (dac_en_o),
    .dac_data_o(dac_data_o)
  );

  assign busy_o     = seq_busy;
  assign reg_we_o   = req.we;
  assign reg_addr_o = req.addr;
  assign reg_data_o = req.data;
endmodule

// File: rtl/fm_wport_chk.sv
module fm_wport_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] port_i,
  input logic       busy_o,
  input logic       reg_we_o,
  input logic [8:0] reg_addr_o,
  input logic [7:0] reg_data_o,
  input logic       mode_we_o,
  input logic       chan_we_o,
  input logic       lfo_clr_o
);
  AST_ADDR_PORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o && !port_i[0]) |-> !reg_we_o); // R1
  AST_DATA_PORT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o && port_i[0]) |-> reg_we_o); // R2
  AST_GROUP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mode_we_o, chan_we_o}) && (reg_we_o == (mode_we_o || chan_we_o))); // R4
  AST_MODE_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_o |-> !reg_addr_o[8]); // R4
  AST_LFO_CLR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfo_clr_o |-> (mode_we_o && reg_addr_o == 9'h022 && !reg_data_o[3])); // R5
  AST_SEQ_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_o) |-> (reg_data_o == 8'h00 && mode_we_o)); // R7
  AST_SEQ_DESCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_o && $past(busy_o && reg_we_o)) |-> (reg_addr_o == $past(reg_addr_o) - 9'd1)); // R7
  AST_SEQ_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(reg_addr_o) == 9'h020 && $past(reg_we_o))); // R7
endmodule

bind fm_host_wport fm_wport_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .port_i    (port_i),
  .busy_o    (busy_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o),
  .reg_data_o(reg_data_o),
  .mode_we_o (mode_we_o),
  .chan_we_o (chan_we_o),
  .lfo_clr_o (lfo_clr_o)
);

// File: tb/fm_host_wport_test.sv
module fm_host_wport_test;
  localparam int HOST_W = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        port = '0;
  logic [HOST_W-1:0] data = '0;
  logic              busy, reg_we, mode_we, chan_we, lfo_clr, dac_en;
  logic [8:0]        reg_addr;
  logic [7:0]        reg_data, dac_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  logic       m_bank = 1'b0;
  logic [7:0] m_addr = '0;
  logic       m_dac_en = 1'b0;
  logic [7:0] m_dac = '0;

  always #5 clk = ~clk;

  fm_host_wport #(.HOST_W(HOST_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .port_i(port), .data_i(data),
    .busy_o(busy), .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_data_o(reg_data),
    .mode_we_o(mode_we), .chan_we_o(chan_we), .lfo_clr_o(lfo_clr),
    .dac_en_o(dac_en), .dac_data_o(dac_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_mode(input logic [8:0] a);
    return (a & 9'h1F0) == 9'h020;
  endfunction

  function automatic bit exp_lfo(input logic [8:0] a, input logic [7:0] d);
    return (a == 9'h022) && !d[3];
  endfunction

  // one host write: drive at negedge, check strobes mid-cycle, update model
  task automatic host_write(input logic [1:0] p, input logic [HOST_W-1:0] d, input string tag);
    logic [8:0] ea;
    logic [7:0] eb;
    @(negedge clk);
    wr_en = 1'b1; port = p; data = d;
    #2;
    eb = d[7:0];
    ea = {m_bank, m_addr};
    if (!p[0]) begin
      chk(reg_we == 1'b0, {tag, " R1 addr-port strobe"}, reg_we, 0);
    end else begin
      chk(reg_we == 1'b1 && reg_addr == ea && reg_data == eb,
          {tag, " R2 R3 data strobe addr/data"}, {reg_we, 3'b0, reg_addr, reg_data}, {4'h1, ea, eb});
      chk(mode_we == is_mode(ea) && chan_we == !is_mode(ea),
          {tag, " R4 group"}, {mode_we, chan_we}, {is_mode(ea), !is_mode(ea)});
      chk(lfo_clr == exp_lfo(ea, eb), {tag, " R5 lfo clear"}, lfo_clr, exp_lfo(ea, eb));
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (!p[0]) begin
      m_bank = p[1]; m_addr = eb;
    end else begin
      if (ea == 9'h02A) m_dac = eb;
      if (ea == 9'h02B) m_dac_en = eb[7];
    end
    chk(dac_en == m_dac_en && dac_data == m_dac, {tag, " R6 dac regs"},
        {dac_en, dac_data}, {m_dac_en, m_dac});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #23;
    chk(busy == 1'b1 && reg_we == 1'b0, "R7 in reset", {busy, reg_we}, 2'b10);
    chk(dac_en == 1'b0 && dac_data == 8'h00, "R8 reset dac", {dac_en, dac_data}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // collide host writes with the sequence
    wr_en = 1'b1; port = 2'b10; data = 16'hAB55;
    #2;
    chk(busy == 1'b1 && reg_we == 1'b0, "R7 R9 arm cycle", {busy, reg_we}, 2'b10);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      port = (i > 3) ? 2'b11 : 2'b10;
      #2;
      chk(busy && reg_we && reg_addr == 9'h026 - 9'(i) && reg_data == 8'h00 && mode_we,
          "R7 R9 seq strobe", {busy, reg_we, reg_addr, reg_data},
          {2'b11, 9'h026 - 9'(i), 8'h00});
    end
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    chk(busy == 1'b0 && reg_we == 1'b0, "R7 busy falls", {busy, reg_we}, 0);

    // nothing latched during busy: data write hits 0x000
    host_write(2'b01, 16'h0011, "R8 R9 first data");

    // bank from latch, not from data port
    host_write(2'b10, 16'h0030, "R1 bank1 latch");
    host_write(2'b01, 16'h0077, "R2 port1 uses bank1");
    host_write(2'b11, 16'h0078, "R10 reuse addr");
    host_write(2'b00, 16'h0021, "R1 bank0 latch");
    host_write(2'b11, 16'h0042, "R2 port3 uses bank0");
    host_write(2'b10, 16'h0021, "R4 bank1 0x121");
    host_write(2'b01, 16'h0042, "R4 0x121 is channel");

    // LFO control
    host_write(2'b00, 16'hFF22, "R3 upper ignored");
    host_write(2'b01, 16'hFF00, "R5 lfo off");
    host_write(2'b01, 16'h0008, "R5 lfo on");
    // DAC
    host_write(2'b00, 16'h002A, "R6 dac addr");
    host_write(2'b01, 16'hC35A, "R3 R6 dac data");
    host_write(2'b00, 16'h002B, "R6 en addr");
    host_write(2'b11, 16'h0080, "R6 en set");
    host_write(2'b11, 16'h007F, "R6 en clear");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [1:0] p;
      logic [HOST_W-1:0] d;
      p = 2'($urandom);
      d = HOST_W'($urandom);
      if (!p[0] && ($urandom % 2 == 0)) d[7:0] = 8'h20 | 8'($urandom % 16);
      host_write(p, d, "RND");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule